// File: doc/BRIEF.md
# Lane Drive-Level Merge Unit

During link training a receiver reports, for every lane, the voltage swing and pre-emphasis it would like the transmitter to use next. This unit collapses those per-lane requests into one drive setting shared by all lanes. It takes the strongest swing and the strongest pre-emphasis asked for by any lane that is in use, and limits the swing to what the transmitter can produce. It then limits the pre-emphasis to a ceiling that depends on the swing it settled on.

The result is packed into a training byte and copied into all four lane slots. A separate flag tells the training sequencer whether every lane in use now sits at the top swing level. Each evaluation is started by a one-cycle `start` pulse. The bytes and `done` are updated on the clock edge that samples `start`.

Top module: `drive_level_merge`

## Requirements
- R1: The chosen swing is the largest swing request among the active lanes, and the chosen pre-emphasis is the largest pre-emphasis request among them. Lane i takes its swing request from `swing_req[2i+1:2i]` and its pre-emphasis request from `preemph_req[2i+1:2i]`.
- R2: Lane i is active only when i < `lane_count`. The requests of inactive lanes have no effect on the result.
- R3: If the chosen swing is greater than or equal to `swing_limit`, the swing becomes `swing_limit` and the swing-limit flag (bit 2) is set. Otherwise the flag is clear.
- R4: The pre-emphasis ceiling is `preemph_ceil[2s+1:2s]`, where s is the swing after the R3 limit. A chosen pre-emphasis at or above this ceiling is replaced by the ceiling and sets the pre-emphasis-limit flag (bit 5). Otherwise the flag is clear.
- R5: The packed byte is swing in bits [1:0], swing-limit flag in bit 2, pre-emphasis in bits [4:3], pre-emphasis-limit flag in bit 5, and bits [7:6] zero. The same byte appears in all four lane slots of `train_set`, with lane i in bits [8i+7:8i], whatever `lane_count` is.
- R6: `all_swing_max` is 1 exactly when every active lane's byte in `train_set` has its swing-limit flag set. The active lanes are those given by the `lane_count` captured with the last `start`.
- R7: While `rst_n` is low, all lane bytes are zero, `done` is 0 and `all_swing_max` is 0.
- R8: The results and `done` = 1 appear on the clock edge that samples `start` high. A single-cycle `start` gives a single-cycle `done`.
- R9: While `start` is low, `train_set` holds its value, even when the request inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin one evaluation |
| lane_count | input | 3 | Number of active lanes (1, 2 or 4) |
| swing_req | input | 8 | Per-lane swing requests, 2 bits per lane |
| preemph_req | input | 8 | Per-lane pre-emphasis requests, 2 bits per lane |
| swing_limit | input | 2 | Highest swing level the transmitter supports |
| preemph_ceil | input | 8 | Pre-emphasis ceiling for each swing level, 2 bits per level |
| train_set | output | 32 | Four lane training bytes |
| all_swing_max | output | 1 | Every active lane at the swing limit |
| done | output | 1 | Evaluation result valid |

## Verification
The properties assume that `lane_count` is never zero. A zero count leaves no lane active, so the "all at limit" flag would be vacuously true and would no longer follow the swing-limit flag in lane 0. The bench only applies counts of 1, 2 and 4. The done-pulse property assumes `start` lasts one cycle, and the bench always pulses it that way. The swing and pre-emphasis limit properties compare against the limit and ceiling inputs as they were on the start cycle. To match this, the bench holds its inputs steady from the start pulse until the check point.

// File: rtl/drive_lvl_pkg.sv
package drive_lvl_pkg;
   localparam int BYTE_W = 8;

   // Pack one lane training byte: swing, swing-limit flag, pre-emphasis, pre-emphasis-limit flag
   function automatic logic [BYTE_W-1:0] pack_lane(
      input logic [1:0] sw, input logic sw_hit,
      input logic [1:0] pe, input logic pe_hit);
      logic [BYTE_W-1:0] b;
      b      = '0;
      b[1:0] = sw;
      b[2]   = sw_hit;
      b[4:3] = pe;
      b[5]   = pe_hit;
      return b;
   endfunction
endpackage

// File: rtl/dlm_lane_reduce.sv
module dlm_lane_reduce #(
   parameter int NUM_LANES = 4,
   parameter int LVL_W     = 2,
   parameter int CNT_W     = 3
) (
   input  logic [CNT_W-1:0]           lane_count,
   input  logic [NUM_LANES*LVL_W-1:0] req,
   output logic [LVL_W-1:0]           max_lvl
);
   logic [LVL_W-1:0] run [NUM_LANES+1];
   assign run[0] = '0;

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      logic act;
      logic [LVL_W-1:0] lvl;
      assign act        = CNT_W'(i) < lane_count;
      assign lvl        = req[i*LVL_W +: LVL_W];
      assign run[i+1]   = (act && (lvl > run[i])) ? lvl : run[i];
   end

   assign max_lvl = run[NUM_LANES];
endmodule

// File: rtl/dlm_clamp.sv
module dlm_clamp #(
   parameter int LVL_W = 2
) (
   input  logic [LVL_W-1:0]              sw_in,
   input  logic [LVL_W-1:0]              pe_in,
   input  logic [LVL_W-1:0]              sw_limit,
   input  logic [(1<<LVL_W)*LVL_W-1:0]   pe_ceil,
   output logic [LVL_W-1:0]              sw_out,
   output logic                          sw_hit,
   output logic [LVL_W-1:0]              pe_out,
   output logic                          pe_hit
);
   logic [LVL_W-1:0] ceil_sel;

   always_comb begin
      sw_hit   = sw_in >= sw_limit;
      sw_out   = sw_hit ? sw_limit : sw_in;
      ceil_sel = pe_ceil[sw_out*LVL_W +: LVL_W];
      pe_hit   = pe_in >= ceil_sel;
      pe_out   = pe_hit ? ceil_sel : pe_in;
   end
endmodule

// File: rtl/dlm_flag_scan.sv
module dlm_flag_scan #(
   parameter int NUM_LANES = 4,
   parameter int CNT_W     = 3,
   parameter int FLAG_BIT  = 2
) (
   input  logic [CNT_W-1:0]       lane_count,
   input  logic [NUM_LANES*8-1:0] lanes,
   output logic                   all_set
);
   logic [NUM_LANES-1:0] ok;

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_scan
      assign ok[i] = (CNT_W'(i) >= lane_count) || lanes[i*8 + FLAG_BIT];
   end

   assign all_set = &ok;
endmodule

// File: rtl/drive_level_merge.sv
module drive_level_merge #(
   parameter int NUM_LANES = 4,
   parameter int LVL_W     = 2,
   localparam int CNT_W    = $clog2(NUM_LANES + 1),
   localparam int NLVL     = 1 << LVL_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [CNT_W-1:0]            lane_count,
   input  logic [NUM_LANES*LVL_W-1:0]  swing_req,
   input  logic [NUM_LANES*LVL_W-1:0]  preemph_req,
   input  logic [LVL_W-1:0]            swing_limit,
   input  logic [NLVL*LVL_W-1:0]       preemph_ceil,
   output logic [NUM_LANES*8-1:0]      train_set,
   output logic                        all_swing_max,
   output logic                        done
);
   import drive_lvl_pkg::*;

   if (LVL_W != 2) begin : g_bad_lvl
      $error("drive_level_merge: lane byte layout needs LVL_W == 2");
   end
   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("drive_level_merge: NUM_LANES must be at least 1");
   end

   logic [LVL_W-1:0] sw_max_req, pe_max_req, sw_fin, pe_fin;
   logic             sw_hit, pe_hit;
   logic [7:0]       lane_byte;
   logic [NUM_LANES*8-1:0] train_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   dlm_lane_reduce #(.NUM_LANES(NUM_LANES), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_sw_max (
      .lane_count (lane_count),
      .req        (swing_req),
      .max_lvl    (sw_max_req)
   );

   dlm_lane_reduce #(.NUM_LANES(NUM_LANES), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_pe_max (
      .lane_count (lane_count),
      .req        (preemph_req),
      .max_lvl    (pe_max_req)
   );

   dlm_clamp #(.LVL_W(LVL_W)) u_clamp (
      .sw_in    (sw_max_req),
      .pe_in    (pe_max_req),
      .sw_limit (swing_limit),
      .pe_ceil  (preemph_ceil),
      .sw_out   (sw_fin),
      .sw_hit   (sw_hit),
      .pe_out   (pe_fin),
      .pe_hit   (pe_hit)
   );

   assign lane_byte = pack_lane(sw_fin, sw_hit, pe_fin, pe_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         train_q <= '0;
         cnt_q   <= CNT_W'(1);
         done_q  <= 1'b0;
      end else begin
         done_q <= start;
         if (start) begin
            train_q <= {NUM_LANES{lane_byte}};
            cnt_q   <= lane_count;
         end
      end
   end

   dlm_flag_scan #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W), .FLAG_BIT(LVL_W)) u_scan (
      .lane_count (cnt_q),
      .lanes      (train_q),
      .all_set    (all_swing_max)
   );

   assign train_set = train_q;
   assign done      = done_q;
endmodule

// File: rtl/drive_level_merge_chk.sv
module drive_level_merge_chk #(
   parameter int NUM_LANES = 4,
   parameter int LVL_W     = 2,
   localparam int CNT_W    = $clog2(NUM_LANES + 1),
   localparam int NLVL     = 1 << LVL_W
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        start,
   input logic [LVL_W-1:0]            swing_limit,
   input logic [NLVL*LVL_W-1:0]       preemph_ceil,
   input logic [NUM_LANES*8-1:0]      train_set,
   input logic                        all_swing_max,
   input logic                        done
);
   function automatic logic [LVL_W-1:0] ceil_at(
      input logic [NLVL*LVL_W-1:0] t, input logic [LVL_W-1:0] s);
      return t[s*LVL_W +: LVL_W];
   endfunction

   logic [LVL_W-1:0] sw0, pe0;
   logic             swf0, pef0;
   assign sw0  = train_set[LVL_W-1:0];
   assign swf0 = train_set[LVL_W];
   assign pe0  = train_set[2*LVL_W:LVL_W+1];
   assign pef0 = train_set[2*LVL_W+1];

   // R8
   done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);
   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);
   // R9
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(train_set));
   // R3
   swing_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (sw0 <= $past(swing_limit)) && (swf0 == (sw0 == $past(swing_limit))));
   // R4
   preemph_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (pe0 <= ceil_at($past(preemph_ceil), sw0))
                && (pef0 == (pe0 == ceil_at($past(preemph_ceil), sw0))));
   // R5
   lanes_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      train_set == {NUM_LANES{train_set[7:0]}});
   // R6
   all_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      all_swing_max == swf0);
endmodule

bind drive_level_merge drive_level_merge_chk #(.NUM_LANES(NUM_LANES), .LVL_W(LVL_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start         (start),
   .swing_limit   (swing_limit),
   .preemph_ceil  (preemph_ceil),
   .train_set     (train_set),
   .all_swing_max (all_swing_max),
   .done          (done)
);

// File: tb/drive_level_merge_bench.sv
`timescale 1ns/1ps
module drive_level_merge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  lane_count = 3'd1;
   logic [7:0]  swing_req = '0;
   logic [7:0]  preemph_req = '0;
   logic [1:0]  swing_limit = 2'd3;
   logic [7:0]  preemph_ceil = 8'h1B;
   logic [31:0] train_set;
   logic        all_swing_max;
   logic        done;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   drive_level_merge u_drive_level_merge (
      .clk(clk), .rst_n(rst_n), .start(start), .lane_count(lane_count),
      .swing_req(swing_req), .preemph_req(preemph_req), .swing_limit(swing_limit),
      .preemph_ceil(preemph_ceil), .train_set(train_set),
      .all_swing_max(all_swing_max), .done(done)
   );

   // {count, swing_req, preemph_req, swing_limit, ceil table, expected byte, expected all-max}
   localparam int NV = 7;
   localparam logic [37:0] VEC [NV] = '{
      {3'd1, 8'hFD, 8'hFC, 2'd3, 8'h1B, 8'h01, 1'b0},
      {3'd2, 8'hF8, 8'hF1, 2'd3, 8'h1B, 8'h2A, 1'b0},
      {3'd4, 8'hC0, 8'h00, 2'd3, 8'h1B, 8'h27, 1'b1},
      {3'd4, 8'h61, 8'h09, 2'd2, 8'h1B, 8'h2E, 1'b1},
      {3'd4, 8'h00, 8'h01, 2'd1, 8'h1B, 8'h08, 1'b0},
      {3'd2, 8'hF1, 8'hF0, 2'd1, 8'h1B, 8'h05, 1'b1},
      {3'd1, 8'h00, 8'h03, 2'd3, 8'hFF, 8'h38, 1'b0}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      summary();
   end

   initial begin
      logic [7:0] eb;
      // R7: reset state
      repeat (3) @(negedge clk);
      chk(train_set == 32'h0, "R7 bytes in reset", train_set, 32'h0);
      chk(done == 1'b0, "R7 done in reset", {31'h0, done}, 32'h0);
      chk(all_swing_max == 1'b0, "R7 all-max in reset", {31'h0, all_swing_max}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R4 R5 R6 R8: table walk
      for (int v = 0; v < NV; v++) begin
         {lane_count, swing_req, preemph_req, swing_limit, preemph_ceil} = VEC[v][37:9];
         eb    = VEC[v][8:1];
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk(done == 1'b1, "R8 done after start", {31'h0, done}, 32'h1);
         for (int l = 0; l < 4; l++)
            chk(train_set[l*8 +: 8] == eb, "R1 R2 R3 R4 R5 lane byte",
                {24'h0, train_set[l*8 +: 8]}, {24'h0, eb});
         chk(all_swing_max == VEC[v][0], "R6 all-max flag",
             {31'h0, all_swing_max}, {31'h0, VEC[v][0]});
         @(negedge clk);
         chk(done == 1'b0, "R8 done single cycle", {31'h0, done}, 32'h0);
      end

      // R9: inputs change without start, outputs hold (last byte 0x38)
      swing_req   = 8'hFF;
      preemph_req = 8'hFF;
      lane_count  = 3'd4;
      swing_limit = 2'd3;
      repeat (3) @(negedge clk);
      chk(train_set == 32'h38383838, "R9 hold without start", train_set, 32'h38383838);
      chk(done == 1'b0, "R9 no done without start", {31'h0, done}, 32'h0);

      // R2: lane 3 alone asks for max swing, count 2 -> swing 0, no flag
      lane_count   = 3'd2;
      swing_req    = 8'hC0;
      preemph_req  = 8'h00;
      preemph_ceil = 8'h1B;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(train_set == 32'h00000000, "R2 inactive lane ignored", train_set, 32'h0);
      chk(all_swing_max == 1'b0, "R6 all-max clear", {31'h0, all_swing_max}, 32'h0);
      @(negedge clk);

      // R7: reset after activity
      swing_req = 8'hFF;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk(train_set == 32'h0, "R7 bytes cleared by reset", train_set, 32'h0);
      chk(all_swing_max == 1'b0, "R7 all-max cleared by reset", {31'h0, all_swing_max}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      summary();
   end
endmodule